// File: doc/BRIEF.md
# Configuration Register Access Port with Dual Banks

This block is the slave end of a serial configuration port. An external controller holds the active-low enable `cfg_en_n` low and clocks bytes in on `mosi`, most significant bit first. The first byte of a frame is a command. It carries a two-bit transfer-mode field, a five-bit register address and a direction flag. A write command stores the byte that follows into the addressed register. A read command makes the block return that register on `miso` during the byte that follows.

The serial pins are brought into the system clock domain through synchronizers and edge detectors. A byte is acted on only when the eighth falling serial clock edge of that byte is seen. Any bits left over when the enable is released are thrown away.

The registers exist in two banks. A shared control register picks the active bank, so that software can switch quickly between two prepared configurations, for example a receive setup and a transmit setup. A rising edge on the `strobe` input also flips the active bank, but only while the active bank is flagged as a receive configuration.

Top module: `cfg_spi_regfile`

## Requirements
- R1: A command byte is shifted in MSB first, with `mosi` sampled on each rising `sclk` edge. Bits [7:6] are the transfer mode, bits [5:1] are the register address and bit [0] is the direction (1 = read, 0 = write).
- R2: A command with mode 2'b01 and direction 0 makes the next byte be stored into the addressed register of the active bank. The store takes effect on the eighth falling `sclk` edge of that data byte.
- R3: A command with mode 2'b01 and direction 1 puts the addressed register of the active bank on `miso`, D7 first, during the next byte. `miso` moves to the next bit on each falling `sclk` edge. `miso` is 0 during command bytes, during the byte after a non-read command, and while the port is disabled.
- R4: Bits that do not complete a byte when `cfg_en_n` goes high are discarded and modify nothing. The next frame always begins with a command byte.
- R5: A command byte whose mode is not 2'b01 changes no register and no bank selection. The byte after it is discarded, and `miso` stays 0 through both bytes.
- R6: While `cfg_en_n` is high, activity on `sclk` and `mosi` has no effect. Holding `cfg_en_n` low with no `sclk` activity changes no register.
- R7: Address CTRL_ADDR (default 31, 15 in the bench build) is a single control register shared by both banks. Bit 0 of a write to it selects the active bank, and a read of it returns {7'b0, active bank}. `act_bank` shows the active bank. Every other address reaches the active bank only.
- R8: A rising edge on `strobe` toggles the active bank when bit 0 of register 0 of the active bank is 1 (receive configuration, also shown on `act_rx`). Otherwise the strobe has no effect.
- R9: Writes to addresses at or above NUM_REGS, other than CTRL_ADDR, are ignored, and reads of those addresses return 0.
- R10: The synchronous active-high reset clears every register of both banks, selects bank 0 and drives `miso`, `act_bank` and `act_rx` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the controller |
| mosi | input | 1 | Serial data into the block |
| cfg_en_n | input | 1 | Active-low configuration access enable |
| strobe | input | 1 | Bank toggle request, acted on at its rising edge |
| miso | output | 1 | Serial read data out |
| act_bank | output | 1 | Currently active bank |
| act_rx | output | 1 | Active bank is flagged as a receive configuration |

## Verification
The bench builds the block with NUM_REGS = 16, which puts the control register at address 15. It leaves SYNC_STAGES at 2. With this build, addresses 16 to 31 form an unmapped range, so ignored writes and zero read-back can be reached from the five-bit address field. It also keeps the shared control register inside the five-bit address space alongside the banked registers. The serial clock runs at eight system clocks per half period, which gives the synchronizer and edge-detector latency room before each sample. This setting lets the bench sample `miso` just before every rising `sclk` edge.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;
    localparam int RX_BIT = 0;

    typedef enum logic [1:0] {
        MODE_00  = 2'b00,
        MODE_CFG = 2'b01,
        MODE_10  = 2'b10,
        MODE_11  = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        xfer_mode_e        mode;
        logic [ADDR_W-1:0] addr;
        logic              rd;
    } cmd_t;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_WR,
        PH_RD,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic cmd_t unpack_cmd(input logic [BYTE_W-1:0] b);
        return cmd_t'(b);
    endfunction

    function automatic logic is_cfg_access(input cmd_t c);
        return c.mode == MODE_CFG;
    endfunction

endpackage

// File: rtl/cfgspi_sync.sv
module cfgspi_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] stg;
            always_ff @(posedge clk) begin
                if (rst) stg <= RST_VAL;
                else     stg <= d;
            end
            assign q = stg;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stg;
            always_ff @(posedge clk) begin
                if (rst) stg <= {STAGES{RST_VAL}};
                else     stg <= {stg[STAGES-2:0], d};
            end
            assign q = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/cfgspi_shifter.sv
module cfgspi_shifter
    import cfgspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic              sclk_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic              rise;
    logic              fall;

    assign rise      = sclk_s & ~sclk_d;
    assign fall      = ~sclk_s & sclk_d;
    assign byte_done = active && fall && (cnt_q == FULL);
    assign rx_byte   = rx_q;
    assign miso      = tx_q[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk_s;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q <= '0;
            rx_q  <= '0;
            tx_q  <= '0;
        end else begin
            if (rise) begin
                rx_q <= {rx_q[BYTE_W-2:0], mosi_s};
                if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
            end
            if (fall) begin
                if (cnt_q == FULL) begin
                    cnt_q <= '0;
                    tx_q  <= tx_load ? tx_data : '0;
                end else begin
                    tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    // R4: releasing the enable leaves no partial byte behind
    a_r4_frame_cleared: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt_q == '0));

endmodule

// File: rtl/cfgspi_ctrl.sv
module cfgspi_ctrl
    import cfgspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output wr_req_t           wr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              tx_load
);

    phase_e phase_q;
    cmd_t   cmd_q;
    cmd_t   cmd_now;

    assign cmd_now = unpack_cmd(rx_byte);
    assign rd_addr = cmd_now.addr;
    assign tx_load = byte_done && (phase_q == PH_CMD) &&
                     is_cfg_access(cmd_now) && cmd_now.rd;

    always_comb begin
        wr.valid = byte_done && (phase_q == PH_WR);
        wr.addr  = cmd_q.addr;
        wr.data  = rx_byte;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            phase_q <= PH_CMD;
            cmd_q   <= '0;
        end else if (byte_done) begin
            case (phase_q)
                PH_CMD: begin
                    cmd_q <= cmd_now;
                    if (!is_cfg_access(cmd_now)) phase_q <= PH_SKIP;
                    else if (cmd_now.rd)         phase_q <= PH_RD;
                    else                         phase_q <= PH_WR;
                end
                default: phase_q <= PH_CMD;
            endcase
        end
    end

    // R2: a data write phase only follows a configuration-mode write command
    a_r2_wr_after_cfg_cmd: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WR) |-> (cmd_q.mode == MODE_CFG) && !cmd_q.rd);

    // R5: a command with a foreign mode never opens a read or write phase
    a_r5_skip_foreign_mode: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SKIP) |-> (cmd_q.mode != MODE_CFG));

endmodule

// File: rtl/cfgspi_banks.sv
module cfgspi_banks
    import cfgspi_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    parameter int CTRL_ADDR = NUM_REGS - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              strobe_rise,
    output logic [BYTE_W-1:0] rd_data,
    output logic              act_bank,
    output logic              act_rx
);

    localparam int NUM_BANKS = 2;
    localparam int IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic [NUM_BANKS-1:0][NUM_REGS-1:0][BYTE_W-1:0] mem_q;
    logic bank_q;
    logic ctrl_hit;
    logic reg_hit;

    assign ctrl_hit = wr.valid && (wr.addr == CTRL_A);
    assign reg_hit  = wr.valid && (wr.addr != CTRL_A) &&
                      (int'(wr.addr) < NUM_REGS);
    assign act_bank = bank_q;
    assign act_rx   = mem_q[bank_q][0][RX_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else if (reg_hit) begin
            mem_q[bank_q][wr.addr[IDX_W-1:0]] <= wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                        bank_q <= 1'b0;
        else if (ctrl_hit)              bank_q <= wr.data[0];
        else if (strobe_rise && act_rx) bank_q <= ~bank_q;
    end

    always_comb begin
        if (rd_addr == CTRL_A)
            rd_data = {{(BYTE_W-1){1'b0}}, bank_q};
        else if (int'(rd_addr) < NUM_REGS)
            rd_data = mem_q[bank_q][rd_addr[IDX_W-1:0]];
        else
            rd_data = '0;
    end

    // R6: storage only changes in a cycle that carries a write
    a_r6_storage_hold: assert property (@(posedge clk) disable iff (rst)
        !wr.valid |=> $stable(mem_q));

    // R8: the bank only moves on a control write or a permitted strobe
    a_r8_bank_change_cause: assert property (@(posedge clk) disable iff (rst)
        !$stable(bank_q) |-> $past(ctrl_hit || (strobe_rise && act_rx)));

endmodule

// File: rtl/cfg_spi_regfile.sv
module cfg_spi_regfile
    import cfgspi_pkg::*;
#(
    parameter int NUM_REGS    = 32,
    parameter int CTRL_ADDR   = NUM_REGS - 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic mosi,
    input  logic cfg_en_n,
    input  logic strobe,
    output logic miso,
    output logic act_bank,
    output logic act_rx
);

    localparam int        SYNC_W   = 4;
    localparam logic [SYNC_W-1:0] SYNC_RST = 4'b0100;

    logic [SYNC_W-1:0] pins_s;
    logic              sclk_s;
    logic              mosi_s;
    logic              en_n_s;
    logic              strobe_s;
    logic              strobe_d;
    logic              strobe_rise;
    logic              active;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_load;
    logic [BYTE_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr;
    wr_req_t           wr;

    cfgspi_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({strobe, cfg_en_n, mosi, sclk}),
        .q   (pins_s)
    );

    assign {strobe_s, en_n_s, mosi_s, sclk_s} = pins_s;
    assign active      = ~en_n_s;
    assign strobe_rise = strobe_s & ~strobe_d;

    always_ff @(posedge clk) begin
        if (rst) strobe_d <= 1'b0;
        else     strobe_d <= strobe_s;
    end

    cfgspi_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .sclk_s    (sclk_s),
        .mosi_s    (mosi_s),
        .tx_load   (tx_load),
        .tx_data   (rd_data),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (miso)
    );

    cfgspi_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .wr        (wr),
        .rd_addr   (rd_addr),
        .tx_load   (tx_load)
    );

    cfgspi_banks #(
        .NUM_REGS  (NUM_REGS),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_banks (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .rd_addr     (rd_addr),
        .strobe_rise (strobe_rise),
        .rd_data     (rd_data),
        .act_bank    (act_bank),
        .act_rx      (act_rx)
    );

    // R3: the serial output is quiet once the port is disabled
    a_r3_miso_quiet_off: assert property (@(posedge clk) disable iff (rst)
        !active |=> !miso);

    // R10: reset leaves outputs at their idle values
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> !miso && !act_bank && !act_rx);

endmodule

// File: tb/cfg_spi_regfile_test.sv
module cfg_spi_regfile_test;

    localparam int NREG  = 16;
    localparam int CTRLA = NREG - 1;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic cfg_en_n = 1'b1;
    logic strobe = 1'b0;
    logic miso;
    logic act_bank;
    logic act_rx;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] mdl [2][32];
    bit         mbank;

    always #2 clk = ~clk;

    cfg_spi_regfile #(.NUM_REGS(NREG)) uut (
        .clk      (clk),
        .rst      (rst),
        .sclk     (sclk),
        .mosi     (mosi),
        .cfg_en_n (cfg_en_n),
        .strobe   (strobe),
        .miso     (miso),
        .act_bank (act_bank),
        .act_rx   (act_rx)
    );

    function automatic logic [7:0] exp_rd(input int a);
        if (a == CTRLA) return {7'b0, mbank};
        if (a < NREG)   return mdl[mbank][a];
        return 8'h00;
    endfunction

    function automatic bit exp_rx();
        return mdl[mbank][0][0];
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n,
                            output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            clks(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            clks(HALF);
            sclk = 1'b0;
        end
        clks(HALF);
    endtask

    task automatic frame(input logic [7:0] b0, input logic [7:0] b1,
                         input int n1, output logic [7:0] r0,
                         output logic [7:0] r1);
        cfg_en_n = 1'b0;
        clks(4);
        spi_bits(b0, 8, r0);
        r1 = 8'h00;
        if (n1 > 0) spi_bits(b1, n1, r1);
        cfg_en_n = 1'b1;
        clks(8);
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        logic [7:0] r0, r1;
        frame({2'b01, 5'(a), 1'b0}, d, 8, r0, r1);
        chk(r0 == 8'h00 && r1 == 8'h00, "R3 miso idle on write", r0 | r1, 8'h00);
        if (a == CTRLA)    mbank = d[0];
        else if (a < NREG) mdl[mbank][a] = d;
        chk(act_bank == mbank, "R7 act_bank after write", {7'b0, act_bank}, {7'b0, mbank});
    endtask

    task automatic do_read(input int a, input string tag);
        logic [7:0] r0, r1;
        frame({2'b01, 5'(a), 1'b1}, 8'h00, 8, r0, r1);
        chk(r0 == 8'h00, "R3 miso zero in command byte", r0, 8'h00);
        chk(r1 == exp_rd(a), tag, r1, exp_rd(a));
    endtask

    task automatic do_strobe();
        if (exp_rx()) mbank = ~mbank;
        strobe = 1'b1;
        clks(6);
        strobe = 1'b0;
        clks(6);
        chk(act_bank == mbank, "R8 bank after strobe", {7'b0, act_bank}, {7'b0, mbank});
        chk(act_rx == exp_rx(), "R8 act_rx after strobe", {7'b0, act_rx}, {7'b0, exp_rx()});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog act=%h exp=%h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] r0, r1;
        int unused_seed;
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < 32; a++) mdl[b][a] = 8'h00;
        mbank = 1'b0;
        unused_seed = $urandom(32'h5EED_1234);

        clks(5);
        rst = 1'b0;
        clks(5);
        // R10: reset state
        chk(miso == 1'b0, "R10 miso reset", {7'b0, miso}, 8'h00);
        chk(act_bank == 1'b0, "R10 bank reset", {7'b0, act_bank}, 8'h00);
        chk(act_rx == 1'b0, "R10 act_rx reset", {7'b0, act_rx}, 8'h00);
        do_read(5, "R10 register cleared");

        // R1 R2 R3: basic write and read-back
        do_write(3, 8'hA5);
        do_read(3, "R2 write then R3 read");
        do_write(6, 8'h81);
        do_read(6, "R1 field order read-back");

        // R7: control register and bank separation
        do_read(CTRLA, "R7 ctrl read bank0");
        do_write(CTRLA, 8'h01);
        do_read(3, "R7 bank1 independent");
        do_write(3, 8'h3C);
        do_read(CTRLA, "R7 ctrl read bank1");
        do_write(CTRLA, 8'h00);
        do_read(3, "R7 bank0 kept");

        // R4: partial trailing bits dropped, framing restarts
        frame({2'b01, 5'd3, 1'b0}, 8'hFF, 5, r0, r1);
        do_read(3, "R4 partial data dropped");
        frame({2'b01, 5'd3, 1'b0}, 8'h00, 0, r0, r1);
        cfg_en_n = 1'b0; clks(4);
        spi_bits(8'h55, 3, r0);
        cfg_en_n = 1'b1; clks(8);
        do_write(4, 8'h4B);
        do_read(4, "R4 framing restarts");

        // R5: foreign mode ignored
        frame({2'b10, 5'd3, 1'b0}, 8'hEE, 8, r0, r1);
        chk((r0 | r1) == 8'h00, "R5 miso quiet foreign mode", r0 | r1, 8'h00);
        do_read(3, "R5 foreign mode no write");
        frame({2'b11, 5'(CTRLA), 1'b0}, 8'h01, 8, r0, r1);
        chk(act_bank == mbank, "R5 bank untouched", {7'b0, act_bank}, {7'b0, mbank});
        frame({2'b00, 5'd3, 1'b1}, 8'h00, 8, r0, r1);
        chk((r0 | r1) == 8'h00, "R5 foreign read returns zero", r0 | r1, 8'h00);

        // R6: disabled port ignores traffic; enable alone changes nothing
        spi_bits({2'b01, 5'd3, 1'b0}, 8, r0);
        spi_bits(8'h99, 8, r1);
        chk(miso == 1'b0, "R6 miso while disabled", {7'b0, miso}, 8'h00);
        do_read(3, "R6 disabled write ignored");
        cfg_en_n = 1'b0; clks(100); cfg_en_n = 1'b1; clks(8);
        do_read(3, "R6 enable alone no change");

        // R9: unmapped addresses
        do_write(20, 8'h77);
        do_read(20, "R9 unmapped read zero");
        do_read(31, "R9 top address zero");

        // R8: strobe toggling
        do_strobe();
        do_write(0, 8'h01);
        chk(act_rx == 1'b1, "R8 act_rx set", {7'b0, act_rx}, 8'h01);
        do_strobe();
        do_strobe();
        do_write(0, 8'h01);
        do_strobe();
        do_strobe();

        // random mix
        for (int n = 0; n < 70; n++) begin
            int sel;
            int a;
            logic [7:0] d;
            sel = int'($urandom_range(0, 9));
            a   = int'($urandom_range(0, 31));
            d   = 8'($urandom);
            if (sel == 0) do_strobe();
            else if (sel == 1) begin
                frame({2'b10 | 2'($urandom_range(0, 1)) << 0 ^ 2'b00, 5'(a), d[0]},
                      d, 8, r0, r1);
                chk(act_bank == mbank, "R5 random foreign mode", {7'b0, act_bank}, {7'b0, mbank});
            end
            else if (sel < 6) do_write(a, d);
            else do_read(a, "R2 random read-back");
        end
        for (int a = 0; a < 32; a++) do_read(a, "R7 final sweep");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule